// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Timed Masking

This block collects request pulses from a group of peripheral sources and a small group of trap sources, and offers the CPU core one interrupt at a time: the most urgent pending one whose level beats the core's current priority. Each peripheral source has a sticky pending flag, an enable bit and a 3-bit priority. Trap sources sit at fixed levels above every peripheral level, and no priority setting or mask can block them.

Software configures the block through a plain address/data/write-enable port. It can set an optional no-nesting switch, and it can start a timed hold-off that blocks peripheral levels 1 to 6 for a programmed number of clock cycles. When the core acknowledges a request, the block drops it and waits for the core's priority to change before it offers another one. A pending flag survives the acknowledge. If software does not clear it, the same interrupt is offered again once the core's priority falls.

Top module: `prio_intc`

## Requirements
- R1: Every peripheral priority field resets to 4. A source that is enabled and flagged right after reset is offered at level 4.
- R2: A peripheral source competes only when its pending flag and its enable bit are both set and its priority is non-zero. Priority 0 disables the source.
- R3: Among competing sources the highest level wins. On equal levels the lower vector index wins. Trap t uses vector t. Peripheral source k uses vector NUM_TRAP+k.
- R4: Trap t has level 8+t. A pending trap beats every peripheral source, the core priority (up to 7) and the timed hold-off.
- R5: `irq_req` is raised only when the winning level is strictly greater than `cpu_level`. It rises one clock after the inputs that enable it, and `irq_vector`/`irq_level` are valid while it is high.
- R6: Writing N to the hold-off address loads a counter with N. The counter decrements once per clock and stops at 0. While it is non-zero, levels 1 to 6 are blocked but level 7 still gets through. Writing again while it runs reloads it.
- R7: With the no-nesting bit set, no request is raised while an acknowledged interrupt is still in service. Service ends when `cpu_level` drops below the acknowledged level.
- R8: Peripheral flags are write-1-to-clear. A source pulse in the same cycle as a clear wins. A flag is not cleared by the acknowledge, so its request returns when `cpu_level` drops below its level.
- R9: Trap flags are set by trap pulses and cleared only by a write-1-to-clear. Once the flag is cleared, the trap is no longer offered.
- R10: When `ack` is high while `irq_req` is high, `irq_req` is low on the next clock. It stays low until `cpu_level` differs from its value at the acknowledge.
- R11: Register addresses are as follows: 0 is the peripheral flags, 1 the enables (plain write), 2 the trap flags, 3 the control register (bit 0 is no-nesting) and 4 the hold-off load. Address 16+k holds source k's priority in bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| src_pulse | input | NUM_SRC | Peripheral request pulses |
| trap_pulse | input | NUM_TRAP | Trap request pulses |
| cpu_level | input | 4 | Current core priority |
| ack | input | 1 | Core takes the offered request |
| irq_req | output | 1 | Request to the core |
| irq_vector | output | VEC_W | Vector index of the offered request |
| irq_level | output | 4 | Level of the offered request, which becomes the new core priority |

## Verification
The bench targets equal-level ties, priority 0 and sources that are flagged but not enabled. An arbiter that got ties wrong would offer the higher vector, and one that ignored the enable would offer a masked source. It runs the hold-off across a reload and checks that level 7 and traps get through it. A counter that fails to reload unmasks too early, and a mask that also blocks level 7 drops an urgent request. It drives a flag clear and a pulse in the same cycle and checks that the flag survives the acknowledge. Wrong precedence loses an interrupt, and clearing the flag on acknowledge stops the request from coming back. It also tries a nested request with the no-nesting switch set and then cleared. A design that ignored the switch would preempt an interrupt that is still in service.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int LVL_W        = 4;
  localparam int PRIO_W       = 3;
  localparam int TRAP_BASE    = 8;
  localparam int PRIO_DEFAULT = 4;
  localparam int ADR_FLAG     = 0;
  localparam int ADR_ENABLE   = 1;
  localparam int ADR_TRAP     = 2;
  localparam int ADR_CTRL     = 3;
  localparam int ADR_HOLDOFF  = 4;
  localparam int ADR_PRIO     = 16;
  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_TRAP = 4,
  parameter int CNT_W    = 8,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [NUM_SRC-1:0]       src_pulse,
  input  logic [NUM_TRAP-1:0]      trap_pulse,
  output logic [NUM_SRC-1:0]       usr_flag,
  output logic [NUM_SRC-1:0]       usr_en,
  output prio_t [NUM_SRC-1:0]      usr_prio,
  output logic [NUM_TRAP-1:0]      trap_flag,
  output logic                     no_nest,
  output logic                     mask_on
);
  logic                sel_flag, sel_en, sel_trap, sel_ctrl, sel_hold;
  logic [NUM_SRC-1:0]  flag_d, en_d;
  logic [NUM_TRAP-1:0] trap_d;
  logic                nn_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;

  always_comb begin
    sel_flag = wr_en && (wr_addr == ADDR_W'(ADR_FLAG));
    sel_en   = wr_en && (wr_addr == ADDR_W'(ADR_ENABLE));
    sel_trap = wr_en && (wr_addr == ADDR_W'(ADR_TRAP));
    sel_ctrl = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
    sel_hold = wr_en && (wr_addr == ADDR_W'(ADR_HOLDOFF));
    flag_d   = (usr_flag & ~(sel_flag ? wr_data[NUM_SRC-1:0] : '0)) | src_pulse;
    trap_d   = (trap_flag & ~(sel_trap ? wr_data[NUM_TRAP-1:0] : '0)) | trap_pulse;
    en_d     = sel_en ? wr_data[NUM_SRC-1:0] : usr_en;
    nn_d     = sel_ctrl ? wr_data[0] : no_nest;
    if (sel_hold)          cnt_d = wr_data[CNT_W-1:0];
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_flag  <= '0;
      usr_en    <= '0;
      trap_flag <= '0;
      no_nest   <= 1'b0;
      cnt_q     <= '0;
    end else begin
      usr_flag  <= flag_d;
      trap_flag <= trap_d;
      cnt_q     <= cnt_d;
      if (sel_en)   usr_en  <= en_d;
      if (sel_ctrl) no_nest <= nn_d;
    end
  end

  assign mask_on = (cnt_q != '0);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_prio
    logic  sel_p;
    assign sel_p = wr_en && (wr_addr == ADDR_W'(ADR_PRIO + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     usr_prio[k] <= prio_t'(PRIO_DEFAULT);
      else if (sel_p) usr_prio[k] <= wr_data[PRIO_W-1:0];
    end
  end
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_TRAP = 4,
  parameter int VEC_W    = 4
) (
  input  logic [NUM_SRC-1:0]  usr_flag,
  input  logic [NUM_SRC-1:0]  usr_en,
  input  prio_t [NUM_SRC-1:0] usr_prio,
  input  logic [NUM_TRAP-1:0] trap_flag,
  input  logic                mask_on,
  output logic                win_valid,
  output logic [VEC_W-1:0]    win_vec,
  output lvl_t                win_lvl
);
  logic [NUM_SRC-1:0] cand;

  always_comb begin
    win_lvl = '0;
    win_vec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      cand[i] = usr_flag[i] && usr_en[i] && (usr_prio[i] != '0)
                && !(mask_on && (usr_prio[i] != prio_t'(7)));
      if (cand[i] && ({1'b0, usr_prio[i]} > win_lvl)) begin
        win_lvl = {1'b0, usr_prio[i]};
        win_vec = VEC_W'(NUM_TRAP + i);
      end
    end
    for (int t = 0; t < NUM_TRAP; t++) begin
      if (trap_flag[t] && (LVL_W'(TRAP_BASE + t) > win_lvl)) begin
        win_lvl = LVL_W'(TRAP_BASE + t);
        win_vec = VEC_W'(t);
      end
    end
    win_valid = (win_lvl != '0);
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_TRAP = 4,
  parameter int CNT_W    = 8,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  localparam int VEC_W   = $clog2(NUM_SRC + NUM_TRAP)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [NUM_SRC-1:0]  src_pulse,
  input  logic [NUM_TRAP-1:0] trap_pulse,
  input  logic [3:0]          cpu_level,
  input  logic                ack,
  output logic                irq_req,
  output logic [VEC_W-1:0]    irq_vector,
  output logic [3:0]          irq_level
);
  logic [NUM_SRC-1:0]  usr_flag, usr_en;
  prio_t [NUM_SRC-1:0] usr_prio;
  logic [NUM_TRAP-1:0] trap_flag;
  logic                no_nest, mask_on;
  logic                win_valid;
  logic [VEC_W-1:0]    win_vec, vec_d;
  lvl_t                win_lvl, lvl_d;
  logic                take, fwd, req_d;
  logic                hold_q, hold_d, active_q, act_d;
  lvl_t                hold_cpu, hold_cpu_d, svc_lvl, svc_d;

  prio_intc_regs #(
    .NUM_SRC(NUM_SRC), .NUM_TRAP(NUM_TRAP), .CNT_W(CNT_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .src_pulse(src_pulse), .trap_pulse(trap_pulse),
    .usr_flag(usr_flag), .usr_en(usr_en), .usr_prio(usr_prio),
    .trap_flag(trap_flag), .no_nest(no_nest), .mask_on(mask_on)
  );

  prio_intc_arb #(
    .NUM_SRC(NUM_SRC), .NUM_TRAP(NUM_TRAP), .VEC_W(VEC_W)
  ) u_arb (
    .usr_flag(usr_flag), .usr_en(usr_en), .usr_prio(usr_prio),
    .trap_flag(trap_flag), .mask_on(mask_on), .win_valid(win_valid),
    .win_vec(win_vec), .win_lvl(win_lvl)
  );

  always_comb begin
    take  = ack && irq_req;
    fwd   = win_valid && (win_lvl > cpu_level) && !hold_q && !(no_nest && active_q);
    req_d = fwd && !take;
    vec_d = fwd ? win_vec : irq_vector;
    lvl_d = fwd ? win_lvl : irq_level;
    if (take)                                       hold_d = 1'b1;
    else if (hold_q && (cpu_level != hold_cpu))     hold_d = 1'b0;
    else                                            hold_d = hold_q;
    hold_cpu_d = take ? cpu_level : hold_cpu;
    if (take)                                       act_d = 1'b1;
    else if (active_q && !hold_q && (cpu_level < svc_lvl)) act_d = 1'b0;
    else                                            act_d = active_q;
    svc_d = take ? irq_level : svc_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req    <= 1'b0;
      irq_vector <= '0;
      irq_level  <= '0;
      hold_q     <= 1'b0;
      hold_cpu   <= '0;
      active_q   <= 1'b0;
      svc_lvl    <= '0;
    end else begin
      irq_req    <= req_d;
      irq_vector <= vec_d;
      irq_level  <= lvl_d;
      hold_q     <= hold_d;
      active_q   <= act_d;
      if (take) begin
        hold_cpu <= hold_cpu_d;
        svc_lvl  <= svc_d;
      end
    end
  end
endmodule

// File: rtl/prio_intc_checker.sv
module prio_intc_checker #(
  parameter int NUM_TRAP = 4,
  parameter int VEC_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       cpu_level,
  input logic             ack,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vector,
  input logic [3:0]       irq_level,
  input logic             mask_on,
  input logic             no_nest,
  input logic             active_q
);
  p_above_cpu_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level > $past(cpu_level)));

  p_holdoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && (irq_level >= 4'd1) && (irq_level <= 4'd6)) |-> !$past(mask_on));

  p_ack_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && ack) |=> !irq_req);

  p_trap_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && (32'(irq_vector) < NUM_TRAP)) |-> (32'(irq_level) == 8 + 32'(irq_vector)));

  p_no_nest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !$past(no_nest && active_q));
endmodule

bind prio_intc prio_intc_checker #(.NUM_TRAP(NUM_TRAP), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_level(cpu_level), .ack(ack),
  .irq_req(irq_req), .irq_vector(irq_vector), .irq_level(irq_level),
  .mask_on(mask_on), .no_nest(no_nest), .active_q(active_q)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  logic        clk, rst_n, wr_en, ack;
  logic [4:0]  wr_addr;
  logic [15:0] wr_data;
  logic [7:0]  src_pulse;
  logic [3:0]  trap_pulse, cpu_level;
  logic        irq_req;
  logic [3:0]  irq_vector, irq_level;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  prio_intc u_prio_intc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .src_pulse(src_pulse), .trap_pulse(trap_pulse),
    .cpu_level(cpu_level), .ack(ack), .irq_req(irq_req),
    .irq_vector(irq_vector), .irq_level(irq_level)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // entry: {enable[8], pulses[8], cpu[4], exp_req[1], exp_vec[4], exp_lvl[4]}
  // priorities: s0=3 s1=5 s2=5 s3=7 s4=0 s5=1 s6=6 s7=2; source k -> vector 4+k
  localparam logic [28:0] VECS [10] = '{
    {8'hFF, 8'h01, 4'd0, 1'b1, 4'd4, 4'd3},  // R5 single source
    {8'hFF, 8'h06, 4'd0, 1'b1, 4'd5, 4'd5},  // R3 tie -> lower index
    {8'hFF, 8'h06, 4'd5, 1'b0, 4'd0, 4'd0},  // R5 equal level blocked
    {8'hFF, 8'h06, 4'd4, 1'b1, 4'd5, 4'd5},  // R5 strictly greater
    {8'hFD, 8'h06, 4'd0, 1'b1, 4'd6, 4'd5},  // R2 disabled source skipped
    {8'hFF, 8'h10, 4'd0, 1'b0, 4'd0, 4'd0},  // R2 priority 0
    {8'hFF, 8'hFF, 4'd0, 1'b1, 4'd7, 4'd7},  // R3 highest level
    {8'hFF, 8'hFF, 4'd7, 1'b0, 4'd0, 4'd0},  // R5 cpu at 7
    {8'h00, 8'hFF, 4'd0, 1'b0, 4'd0, 4'd0},  // R2 nothing enabled
    {8'hFF, 8'hA1, 4'd0, 1'b1, 4'd4, 4'd3}   // R3 mixed low levels
  };

  task automatic check(input string rq, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", rq, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] s, input logic [3:0] t);
    @(negedge clk);
    src_pulse = s; trap_pulse = t;
    @(negedge clk);
    src_pulse = '0; trap_pulse = '0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ack = 1'b0;
    src_pulse = '0; trap_pulse = '0; cpu_level = '0;
    cyc(3);
    check("R11 reset req", 16'(irq_req), 16'd0);
    @(negedge clk) rst_n = 1'b1;
    cyc(2);

    // R1: default priority 4
    wr(1, 8'h01);
    pulse(8'h01, 4'h0);
    cyc(3);
    check("R1 req", 16'(irq_req), 16'd1);
    check("R1 level", 16'(irq_level), 16'd4);
    check("R1 vector", 16'(irq_vector), 16'd4);

    wr(16, 3); wr(17, 5); wr(18, 5); wr(19, 7);
    wr(20, 0); wr(21, 1); wr(22, 6); wr(23, 2);

    for (int e = 0; e < 10; e++) begin
      logic [28:0] v;
      v = VECS[e];
      wr(0, 8'hFF);
      wr(1, v[28:21]);
      cpu_level = v[12:9];
      pulse(v[20:13], 4'h0);
      cyc(3);
      check($sformatf("R3/R5 table %0d req", e), 16'(irq_req), 16'(v[8]));
      if (v[8]) begin
        check($sformatf("R3 table %0d vec", e), 16'(irq_vector), 16'(v[7:4]));
        check($sformatf("R3 table %0d lvl", e), 16'(irq_level), 16'(v[3:0]));
      end
    end

    // R4 / R9: traps
    wr(0, 8'hFF);
    wr(1, 8'hFF);
    cpu_level = 4'd7;
    pulse(8'h08, 4'h4);
    cyc(3);
    check("R4 trap req", 16'(irq_req), 16'd1);
    check("R4 trap vec", 16'(irq_vector), 16'd2);
    check("R4 trap lvl", 16'(irq_level), 16'd10);
    wr(2, 4'h4);
    cyc(3);
    check("R9 trap cleared", 16'(irq_req), 16'd0);
    cpu_level = 4'd0;
    wr(0, 8'hFF);

    // R6: timed hold-off
    wr(4, 40);
    pulse(8'h02, 4'h0);
    cyc(3);
    check("R6 level5 held", 16'(irq_req), 16'd0);
    pulse(8'h08, 4'h0);
    cyc(3);
    check("R6 level7 passes", 16'(irq_level), 16'd7);
    check("R6 level7 req", 16'(irq_req), 16'd1);
    pulse(8'h00, 4'h2);
    cyc(3);
    check("R6 trap passes", 16'(irq_level), 16'd9);
    wr(2, 4'hF);
    wr(0, 8'h08);
    cyc(3);
    check("R6 still held", 16'(irq_req), 16'd0);
    cyc(40);
    check("R6 expired", 16'(irq_req), 16'd1);
    check("R6 expired lvl", 16'(irq_level), 16'd5);
    wr(4, 10);
    cyc(6);
    wr(4, 10);
    cyc(6);
    check("R6 reload holds", 16'(irq_req), 16'd0);
    cyc(10);
    check("R6 reload expires", 16'(irq_req), 16'd1);

    // R10 / R8: acknowledge and re-request
    do_ack();
    check("R10 drop after ack", 16'(irq_req), 16'd0);
    cyc(3);
    check("R10 held at same cpu", 16'(irq_req), 16'd0);
    cpu_level = 4'd5;
    cyc(3);
    check("R5 equal after ack", 16'(irq_req), 16'd0);
    cpu_level = 4'd0;
    cyc(3);
    check("R8 re-request", 16'(irq_req), 16'd1);
    check("R8 re-request vec", 16'(irq_vector), 16'd5);

    // R8: pulse beats clear
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd0; wr_data = 16'h0002; src_pulse = 8'h02;
    @(negedge clk);
    wr_en = 1'b0; src_pulse = '0;
    cyc(3);
    check("R8 pulse wins", 16'(irq_req), 16'd1);
    wr(0, 8'h02);
    cyc(3);
    check("R8 clear", 16'(irq_req), 16'd0);

    // R7: no nesting
    wr(3, 1);
    pulse(8'h02, 4'h0);
    cyc(3);
    do_ack();
    cpu_level = 4'd5;
    pulse(8'h08, 4'h0);
    cyc(3);
    check("R7 no preempt", 16'(irq_req), 16'd0);
    cpu_level = 4'd0;
    cyc(3);
    check("R7 after service", 16'(irq_req), 16'd1);
    check("R7 after service lvl", 16'(irq_level), 16'd7);
    wr(3, 0);
    wr(0, 8'hFF);
    pulse(8'h02, 4'h0);
    cyc(3);
    do_ack();
    cpu_level = 4'd5;
    pulse(8'h08, 4'h0);
    cyc(3);
    check("R7 nesting allowed", 16'(irq_req), 16'd1);
    check("R7 nesting lvl", 16'(irq_level), 16'd7);

    finish_run();
  end
endmodule